// File: doc/BRIEF.md
# Four-Channel 8-bit Reload Timer Bank

This block holds four independent 8-bit down-counting timers behind one byte-wide register bus. Each timer has three registers: a control byte, a reload value and the live count. The control byte selects what drives the count. Codes 0 to 6 pick one of seven single-cycle tick inputs from an outside prescaler. Code 7 picks that timer's own external pin, and each rising edge of the pin counts once. The control byte also has a run bit and an initialise bit. When a selected tick arrives while the count is zero, the timer reloads from its reload value and its square-wave output toggles.

Each channel runs a three-state machine whose state register follows the control byte one cycle later. The states are IDLE (stopped), COUNT (running) and PRELOAD (initialising). PRELOAD is entered whenever the initialise bit is 1, whatever the run bit holds. COUNT is entered when only the run bit is 1. IDLE is entered when both bits are 0. Every transition between these states is taken directly on the next clock after the control byte changes: IDLE to COUNT, IDLE to PRELOAD, COUNT to IDLE, COUNT to PRELOAD, PRELOAD to IDLE and PRELOAD to COUNT. In PRELOAD the count copies the reload value on every clock and the output is held low. In IDLE nothing moves. In COUNT a selected tick decrements the count, or reloads it and toggles the output when it is at zero.

The bus address is split into a region in the upper two bits and a timer index in the lower two bits. Region 0 holds the control bytes, region 1 the reload values, region 2 the counts (read-only), and region 3 reads as zero. Reads are combinational. Writes take effect at the clock edge on which the write strobe is high.

Top module: `reload_timer_bank`

## Requirements
- R1: After reset, every control byte, reload value and count reads 0, and all four timer outputs are low.
- R2: Writing a control byte (address 0+n) stores bits 7, 6 and 2:0. Bits 5:3 always read 0, whatever was written to them.
- R3: Writing a reload value (address 4+n) stores the whole byte, and reading it returns that byte, separately for each timer.
- R4: While control bit 6 (initialise) is 1, the count (address 8+n) follows the reload value on every clock and the timer output is low.
- R5: While bits 7 and 6 are both 0, the count and the output hold their values no matter which ticks arrive.
- R6: While only bit 7 (run) is 1, each tick on the source chosen by bits 2:0 lowers a nonzero count by one. Ticks on other sources change nothing.
- R7: In the running state, a selected tick that finds the count at 0 loads the reload value and inverts the timer output, so the output toggles every reload+1 ticks. A reload value of 0 toggles it on every tick.
- R8: With source code 7, each rising edge of that timer's external pin counts exactly once, however long the pin stays high.
- R9: With bits 7 and 6 both 1, initialise wins: the count keeps loading the reload value and does not count.
- R10: Writes to the count addresses (8+n) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | 4 | Byte address: region in bits 3:2, timer index in bits 1:0 |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| int_tick | input | 7 | Prescaled single-cycle tick strobes, source codes 0 to 6 |
| ext_pin | input | 4 | External count pins, one per timer, asynchronous |
| tmr_out | output | 4 | Square-wave output of each timer |

## Verification
The assertions assume that the internal tick inputs are single-cycle strobes driven synchronously to clk. They also assume that each external pin stays at a level for at least two clocks, so the synchronizer sees every edge. The bench drives ticks for exactly one cycle at a time, from the falling edge. It holds each external pin level for four clocks. Before checking, it waits out the one-cycle lag between a control write and the state register. The run and initialise bits are also written together on purpose, and the assertions state what must happen in that case rather than treating it as illegal input.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int unsigned DATA_W   = 8;
    localparam int unsigned SEL_W    = 3;
    localparam int unsigned RUN_BIT  = 7;
    localparam int unsigned INIT_BIT = 6;
    // Control bits kept in storage: run, initialise and the source select
    localparam logic [DATA_W-1:0] MODE_KEEP = 8'hC7;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COUNT   = 2'd1,
        ST_PRELOAD = 2'd2
    } tmr_state_e;

    // Initialise has priority over run
    function automatic tmr_state_e next_state(input logic run, input logic init);
        if (init)     return ST_PRELOAD;
        else if (run) return ST_COUNT;
        else          return ST_IDLE;
    endfunction

endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);
    logic [2:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[1:0], pin};
    end

    // sync_q[1] is the second synchronizer stage, sync_q[2] its delayed copy
    assign rise = sync_q[1] & ~sync_q[2];
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int unsigned NUM_INT = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              init,
    input  logic [SEL_W-1:0]  sel,
    input  logic [NUM_INT-1:0] int_tick,
    input  logic              ext_rise,
    input  logic [DATA_W-1:0] reload,
    output logic [DATA_W-1:0] count,
    output logic              wave,
    output tmr_state_e        state,
    output logic              tick
);
    localparam logic [SEL_W-1:0] EXT_CODE = {SEL_W{1'b1}};

    tmr_state_e state_q;

    // Source selection; a code with no source yields no tick
    always_comb begin
        tick = 1'b0;
        if (sel == EXT_CODE)
            tick = ext_rise;
        else if (32'(sel) < NUM_INT)
            tick = int_tick[sel];
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= next_state(run, init);
    end

    // Output/datapath process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
            wave  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_PRELOAD: begin
                    count <= reload;
                    wave  <= 1'b0;
                end
                ST_COUNT: begin
                    if (tick) begin
                        if (count == '0) begin
                            count <= reload;
                            wave  <= ~wave;
                        end else begin
                            count <= count - 1'b1;
                        end
                    end
                end
                ST_IDLE: begin
                    count <= count;
                    wave  <= wave;
                end
                default: begin
                    count <= count;
                    wave  <= wave;
                end
            endcase
        end
    end

    assign state = state_q;
endmodule

// File: rtl/reload_timer_bank.sv
module reload_timer_bank
    import tmr_pkg::*;
#(
    parameter int unsigned N_TMR   = 4,
    parameter int unsigned NUM_INT = 7,
    parameter int unsigned ADDR_W  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_INT-1:0]  int_tick,
    input  logic [N_TMR-1:0]    ext_pin,
    output logic [N_TMR-1:0]    tmr_out
);
    localparam int unsigned IDX_W = (N_TMR > 1) ? $clog2(N_TMR) : 1;
    localparam int unsigned RGN_W = ADDR_W - IDX_W;
    localparam logic [RGN_W-1:0] RGN_MODE = RGN_W'(0);
    localparam logic [RGN_W-1:0] RGN_BASE = RGN_W'(1);
    localparam logic [RGN_W-1:0] RGN_CNT  = RGN_W'(2);

    logic [RGN_W-1:0] rgn;
    logic [IDX_W-1:0] idx;
    assign rgn = bus_addr[ADDR_W-1:IDX_W];
    assign idx = bus_addr[IDX_W-1:0];

    logic [N_TMR-1:0][DATA_W-1:0] mode_q;
    logic [N_TMR-1:0][DATA_W-1:0] base_q;
    logic [N_TMR-1:0][DATA_W-1:0] cnt_w;
    tmr_state_e [N_TMR-1:0]       st_w;
    logic [N_TMR-1:0]             tick_w;
    logic [N_TMR-1:0]             rise_w;

    // Register writes; the count region has no write path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            base_q <= '0;
        end else if (bus_we) begin
            for (int i = 0; i < int'(N_TMR); i++) begin
                if (idx == IDX_W'(i)) begin
                    if (rgn == RGN_MODE) mode_q[i] <= bus_wdata & MODE_KEEP;
                    if (rgn == RGN_BASE) base_q[i] <= bus_wdata;
                end
            end
        end
    end

    // Readback
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < int'(N_TMR); i++) begin
            if (idx == IDX_W'(i)) begin
                if (rgn == RGN_MODE) bus_rdata = mode_q[i];
                if (rgn == RGN_BASE) bus_rdata = base_q[i];
                if (rgn == RGN_CNT)  bus_rdata = cnt_w[i];
            end
        end
    end

    for (genvar g = 0; g < int'(N_TMR); g++) begin : g_tmr
        tmr_edge_sync u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (ext_pin[g]),
            .rise  (rise_w[g])
        );

        tmr_channel #(.NUM_INT(NUM_INT)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (mode_q[g][RUN_BIT]),
            .init     (mode_q[g][INIT_BIT]),
            .sel      (mode_q[g][SEL_W-1:0]),
            .int_tick (int_tick),
            .ext_rise (rise_w[g]),
            .reload   (base_q[g]),
            .count    (cnt_w[g]),
            .wave     (tmr_out[g]),
            .state    (st_w[g]),
            .tick     (tick_w[g])
        );
    end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
    import tmr_pkg::*;
#(
    parameter int unsigned N_TMR  = 4,
    parameter int unsigned ADDR_W = 4
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [ADDR_W-1:0]            bus_addr,
    input logic [DATA_W-1:0]            bus_rdata,
    input logic [N_TMR-1:0][DATA_W-1:0] mode_q,
    input logic [N_TMR-1:0][DATA_W-1:0] base_q,
    input logic [N_TMR-1:0][DATA_W-1:0] cnt_w,
    input tmr_state_e [N_TMR-1:0]       st_w,
    input logic [N_TMR-1:0]             tick_w,
    input logic [N_TMR-1:0]             tmr_out
);
    localparam int unsigned IDX_W = (N_TMR > 1) ? $clog2(N_TMR) : 1;

    // R2: reserved control bits never read back as 1
    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[ADDR_W-1:IDX_W] == '0) |-> (bus_rdata[5:3] == 3'b000));

    for (genvar g = 0; g < int'(N_TMR); g++) begin : g_chk
        p_preload_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (st_w[g] == ST_PRELOAD) |=> (cnt_w[g] == $past(base_q[g])) && !tmr_out[g]);

        p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (st_w[g] == ST_IDLE) |=> $stable(cnt_w[g]) && $stable(tmr_out[g]));

        p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (st_w[g] == ST_COUNT && tick_w[g] && cnt_w[g] != '0)
            |=> (cnt_w[g] == DATA_W'($past(cnt_w[g]) - 1'b1)) && $stable(tmr_out[g]));

        p_no_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (st_w[g] == ST_COUNT && !tick_w[g]) |=> $stable(cnt_w[g]) && $stable(tmr_out[g]));

        p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (st_w[g] == ST_COUNT && tick_w[g] && cnt_w[g] == '0)
            |=> (cnt_w[g] == $past(base_q[g])) && (tmr_out[g] != $past(tmr_out[g])));

        p_init_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q[g][RUN_BIT] && mode_q[g][INIT_BIT]) |=> (st_w[g] == ST_PRELOAD));
    end
endmodule

bind reload_timer_bank tmr_checker #(.N_TMR(N_TMR), .ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .mode_q    (mode_q),
    .base_q    (base_q),
    .cnt_w     (cnt_w),
    .st_w      (st_w),
    .tick_w    (tick_w),
    .tmr_out   (tmr_out)
);

// File: tb/reload_timer_bank_tb.sv
module reload_timer_bank_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [6:0] int_tick = '0;
    logic [3:0] ext_pin = '0;
    logic [3:0] tmr_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    reload_timer_bank dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .int_tick  (int_tick),
        .ext_pin   (ext_pin),
        .tmr_out   (tmr_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse(input int k);
        @(negedge clk);
        int_tick = 7'(1 << k);
        @(negedge clk);
        int_tick = '0;
    endtask

    task automatic model(inout int c, inout bit o, input int b);
        if (c == 0) begin c = b; o = ~o; end
        else c = c - 1;
    endtask

    task automatic expect_tmr(input int t, input int c, input bit o, input string req);
        logic [7:0] d;
        rd(4'(8 + t), d);
        check(d == 8'(c), req, d, c);
        check(tmr_out[t] == o, req, int'(tmr_out[t]), int'(o));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
        end
    end

    initial begin
        logic [7:0] d;
        int c;
        bit o;

        idle(3);
        // R1: reset state of all registers and outputs
        for (int a = 0; a < 12; a++) begin
            rd(4'(a), d);
            check(d == 8'h00, "R1", d, 0);
        end
        check(tmr_out == 4'b0, "R1", tmr_out, 0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        // R2: exhaustive control byte write/read on timer 0
        for (int v = 0; v < 256; v++) begin
            wr(4'd0, 8'(v));
            rd(4'd0, d);
            check(d == (8'(v) & 8'hC7), "R2", d, v & 8'hC7);
        end
        wr(4'd0, 8'h00);

        // R3: exhaustive reload write/read on timer 1, then distinct values per timer
        for (int v = 0; v < 256; v++) begin
            wr(4'd5, 8'(v));
            rd(4'd5, d);
            check(d == 8'(v), "R3", d, v);
        end
        for (int t = 0; t < 4; t++) wr(4'(4 + t), 8'(8'h30 + 8'h11 * t));
        for (int t = 0; t < 4; t++) begin
            rd(4'(4 + t), d);
            check(d == 8'(8'h30 + 8'h11 * t), "R3", d, 8'h30 + 8'h11 * t);
        end

        // R10: count region ignores writes
        for (int t = 0; t < 4; t++) wr(4'(8 + t), 8'h5A);
        for (int t = 0; t < 4; t++) begin
            rd(4'(8 + t), d);
            check(d == 8'h00, "R10", d, 0);
        end

        // R4: initialise copies reload and tracks later reload changes
        for (int t = 0; t < 4; t++) begin
            wr(4'(t), 8'h40);
            idle(2);
            expect_tmr(t, 8'h30 + 8'h11 * t, 1'b0, "R4");
            wr(4'(4 + t), 8'(8'hA0 + t));
            idle(1);
            expect_tmr(t, 8'hA0 + t, 1'b0, "R4");
            wr(4'(t), 8'h00);
            idle(2);
            // R5: stopped timer holds through ticks on every source
            for (int k = 0; k < 7; k++) pulse(k);
            expect_tmr(t, 8'hA0 + t, 1'b0, "R5");
        end

        // R6/R7: each timer with each internal source, reload value = source code
        for (int t = 0; t < 4; t++) begin
            for (int s = 0; s < 7; s++) begin
                wr(4'(4 + t), 8'(s));
                wr(4'(t), 8'(8'h40 | s));
                idle(2);
                wr(4'(t), 8'(8'h80 | s));
                idle(2);
                c = s; o = 1'b0;
                expect_tmr(t, c, o, "R4");
                for (int k = 0; k < 2 * (s + 1) + 1; k++) begin
                    bit wrap;
                    wrap = (c == 0);
                    pulse(s);
                    model(c, o, s);
                    expect_tmr(t, c, o, wrap ? "R7" : "R6");
                    pulse((s + 1) % 7);
                    expect_tmr(t, c, o, "R6");
                end
                // R5: stop mid-count, ticks must not move it
                wr(4'(t), 8'(s));
                idle(2);
                repeat (3) pulse(s);
                expect_tmr(t, c, o, "R5");
                wr(4'(t), 8'h00);
            end
        end

        // R8: external pin source on timer 2, reload 5
        wr(4'd6, 8'd5);
        wr(4'd2, 8'h47);
        idle(2);
        wr(4'd2, 8'h87);
        idle(2);
        c = 5; o = 1'b0;
        for (int k = 0; k < 14; k++) begin
            @(negedge clk);
            ext_pin[2] = 1'b1;
            ext_pin[3] = 1'b1;
            idle(4);
            ext_pin[2] = 1'b0;
            ext_pin[3] = 1'b0;
            int_tick = 7'h7F;
            @(negedge clk);
            int_tick = '0;
            idle(3);
            model(c, o, 5);
            expect_tmr(2, c, o, "R8");
        end
        // R8: pin held high for a long time counts once
        @(negedge clk);
        ext_pin[2] = 1'b1;
        idle(20);
        model(c, o, 5);
        expect_tmr(2, c, o, "R8");
        ext_pin[2] = 1'b0;
        idle(4);
        wr(4'd2, 8'h00);

        // R9: run and initialise together, initialise wins
        wr(4'd4, 8'd9);
        wr(4'd0, 8'hC0);
        idle(2);
        repeat (5) pulse(0);
        expect_tmr(0, 9, 1'b0, "R9");
        wr(4'd4, 8'd3);
        idle(1);
        pulse(0);
        expect_tmr(0, 3, 1'b0, "R9");

        done = 1'b1;
        summary();
    end
endmodule